// File: doc/BRIEF.md
# ADC Power-Up Sequencing Controller

This block drives the three power switches of an analog-to-digital converter: the bandgap enable, the reference enable and the converter core enable. In the staged start-up it turns on bandgap and reference first and waits for them to settle. It then turns on the core and waits for the core to settle. Only after both waits does it raise a registered ready flag. In the single-step start-up it turns on all three switches in the same cycle and makes one long wait before ready. Conversion requests pass through to the converter only while ready is high. A request made earlier is dropped and answered with an error pulse.

A two-bit mode input selects one of four power settings. RUN (0) is fully powered. BIAS (1) keeps bandgap and reference on, powers the core down and keeps the converter clock running. DOWN (2) switches off all three enables but keeps the clock. DEEP (3) switches off all three enables and also stops the clock. The converter clock is a one-cycle enable pulse that fires every `ADC_DIV` system cycles. Its default of 8 gives 12.5 MHz from a 100 MHz system clock. The default settling counts come from `SYS_CLK_HZ`: 5 ms for the bandgap and 50 µs (the worst case) for the core.

The state machine has six states:
- OFF: all enables low.
- BG_SETTLE: bandgap and reference on, counting the bandgap wait.
- STANDBY: bandgap settled, core off.
- CORE_SETTLE: core on, counting the core wait.
- ALL_SETTLE: single-step, everything on, counting the bandgap wait.
- READY: fully powered and settled.

Its transitions are:
- OFF→BG_SETTLE on RUN with staged start-up, or on BIAS.
- OFF→ALL_SETTLE on RUN with single-step start-up.
- BG_SETTLE→CORE_SETTLE when the wait ends in RUN.
- BG_SETTLE→STANDBY when the wait ends in BIAS.
- STANDBY→CORE_SETTLE on RUN.
- CORE_SETTLE→READY and ALL_SETTLE→READY when the wait ends.
- CORE_SETTLE→STANDBY and READY→STANDBY on BIAS.
- ALL_SETTLE→BG_SETTLE on BIAS, which restarts the bandgap wait.
- Any state→OFF on DOWN or DEEP.

Top module: `adc_pwrseq`

## Requirements
- R1: `core_en` is never high unless `bg_en` and `ref_en` are both high. In the staged start-up, bandgap and reference rise one or more cycles before the core.
- R2: In the staged start-up from OFF, `core_en` rises exactly `BG_CYC` cycles after `bg_en` and `ref_en` rise.
- R3: After `core_en` rises in the staged start-up, `ready` rises exactly `CORE_CYC` cycles later.
- R4: With `single_step` high, a start-up from OFF raises `bg_en`, `ref_en` and `core_en` at the same clock edge, and `ready` rises exactly `BG_CYC` cycles after that edge.
- R5: `conv_go` equals `conv_req` in the same cycle while `ready` is high. While `ready` is low, `conv_go` stays low.
- R6: For each cycle in which `conv_req` is high while `ready` is low, `conv_err` is high in the following cycle only.
- R7: In mode BIAS (`mode_sel`=1), bandgap and reference are on and settled while `core_en` and `ready` stay low. Entering BIAS from READY drops `ready` and `core_en` at the next clock edge.
- R8: In mode DOWN (2) or DEEP (3), all three enables and `ready` are low from the next clock edge.
- R9: `adc_clk_en` pulses for one cycle out of every `ADC_DIV` cycles in modes RUN, BIAS and DOWN, and never pulses in DEEP.
- R10: Returning to RUN from settled BIAS restarts at the core stage: `core_en` rises at the next edge and `ready` rises `CORE_CYC` cycles after that.
- R11: While reset is asserted, all outputs are low and the controller is in OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Power mode: 0 RUN, 1 BIAS, 2 DOWN, 3 DEEP |
| single_step | input | 1 | 1 selects the all-at-once start-up, 0 the staged one |
| conv_req | input | 1 | Conversion request from the sequencer |
| bg_en | output | 1 | Bandgap enable |
| ref_en | output | 1 | Reference enable |
| core_en | output | 1 | Converter core enable (high = powered up) |
| adc_clk_en | output | 1 | Converter clock enable pulse |
| ready | output | 1 | Converter powered and settled |
| conv_go | output | 1 | Forwarded conversion start |
| conv_err | output | 1 | Rejected-request pulse |

## Verification
The bench builds the block with `BG_CYC`=40, `CORE_CYC`=12 and `ADC_DIV`=8. The full default counts would take hundreds of thousands of cycles per start-up. These short values make it possible to count every cycle of both settling waits and of the single-step wait exactly. With them, one run can cover every mode change, including BIAS re-entry and the clock-gating modes. Because `CORE_CYC` is shorter than `BG_CYC`, the core-settle and bandgap-settle windows can be told apart by their lengths.

// File: rtl/adc_pwrseq_pkg.sv
package adc_pwrseq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_BIAS = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_DEEP = 2'd3
    } adc_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BG_SETTLE,
        ST_STANDBY,
        ST_CORE_SETTLE,
        ST_ALL_SETTLE,
        ST_READY
    } pwr_state_e;

endpackage

// File: rtl/adc_pwrseq_timer.sv
module adc_pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    // Down counter; a load wins over the decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/adc_pwrseq_clkdiv.sv
module adc_pwrseq_clkdiv #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_count
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] phase;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            assign tick = (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/adc_pwrseq_fsm.sv
module adc_pwrseq_fsm
    import adc_pwrseq_pkg::*;
#(
    parameter int BG_CYC   = 500000,
    parameter int CORE_CYC = 5000,
    parameter int CNT_W    = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  adc_mode_e        mode,
    input  logic             single_step,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             bg_on,
    output logic             core_on,
    output logic             rdy
);
    localparam logic [CNT_W-1:0] BG_LOAD   = CNT_W'(BG_CYC - 1);
    localparam logic [CNT_W-1:0] CORE_LOAD = CNT_W'(CORE_CYC - 1);

    pwr_state_e state, nxt;
    logic       want_off;

    assign want_off = (mode == MODE_DOWN) || (mode == MODE_DEEP);

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (mode == MODE_RUN)       nxt = single_step ? ST_ALL_SETTLE : ST_BG_SETTLE;
                else if (mode == MODE_BIAS) nxt = ST_BG_SETTLE;
            end
            ST_BG_SETTLE: begin
                if (want_off)     nxt = ST_OFF;
                else if (expired) nxt = (mode == MODE_RUN) ? ST_CORE_SETTLE : ST_STANDBY;
            end
            ST_STANDBY: begin
                if (want_off)              nxt = ST_OFF;
                else if (mode == MODE_RUN) nxt = ST_CORE_SETTLE;
            end
            ST_CORE_SETTLE: begin
                if (want_off)               nxt = ST_OFF;
                else if (mode == MODE_BIAS) nxt = ST_STANDBY;
                else if (expired)           nxt = ST_READY;
            end
            ST_ALL_SETTLE: begin
                if (want_off)               nxt = ST_OFF;
                else if (mode == MODE_BIAS) nxt = ST_BG_SETTLE;
                else if (expired)           nxt = ST_READY;
            end
            ST_READY: begin
                if (want_off)               nxt = ST_OFF;
                else if (mode == MODE_BIAS) nxt = ST_STANDBY;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // Timer load on entry to a waiting state
    always_comb begin
        load     = 1'b0;
        load_val = BG_LOAD;
        if (nxt != state) begin
            unique case (nxt)
                ST_BG_SETTLE, ST_ALL_SETTLE: begin
                    load     = 1'b1;
                    load_val = BG_LOAD;
                end
                ST_CORE_SETTLE: begin
                    load     = 1'b1;
                    load_val = CORE_LOAD;
                end
                default: begin
                    load     = 1'b0;
                    load_val = BG_LOAD;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg_on   <= 1'b0;
            core_on <= 1'b0;
            rdy     <= 1'b0;
        end else begin
            bg_on   <= (nxt != ST_OFF);
            core_on <= (nxt == ST_CORE_SETTLE) || (nxt == ST_ALL_SETTLE) || (nxt == ST_READY);
            rdy     <= (nxt == ST_READY);
        end
    end
endmodule

// File: rtl/adc_pwrseq.sv
module adc_pwrseq
    import adc_pwrseq_pkg::*;
#(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int BG_CYC     = SYS_CLK_HZ / 200,
    parameter int CORE_CYC   = SYS_CLK_HZ / 20_000,
    parameter int ADC_DIV    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       single_step,
    input  logic       conv_req,
    output logic       bg_en,
    output logic       ref_en,
    output logic       core_en,
    output logic       adc_clk_en,
    output logic       ready,
    output logic       conv_go,
    output logic       conv_err
);
    localparam int MAX_CYC = (BG_CYC > CORE_CYC) ? BG_CYC : CORE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    adc_mode_e        mode;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_expired;
    logic             div_tick;
    logic             bg_on;
    logic             core_on;
    logic             rdy;
    logic             err_q;

    assign mode = adc_mode_e'(mode_sel);

    adc_pwrseq_fsm #(
        .BG_CYC  (BG_CYC),
        .CORE_CYC(CORE_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .single_step(single_step),
        .expired    (t_expired),
        .load       (t_load),
        .load_val   (t_val),
        .bg_on      (bg_on),
        .core_on    (core_on),
        .rdy        (rdy)
    );

    adc_pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_expired)
    );

    adc_pwrseq_clkdiv #(.DIV(ADC_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (div_tick)
    );

    // Rejected request flag, one cycle per rejected request cycle
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= conv_req && !rdy;
    end

    assign bg_en      = bg_on;
    assign ref_en     = bg_on;
    assign core_en    = core_on;
    assign ready      = rdy;
    assign conv_go    = conv_req && rdy;
    assign conv_err   = err_q;
    assign adc_clk_en = div_tick && (mode != MODE_DEEP);
endmodule

// File: rtl/adc_pwrseq_chk.sv
module adc_pwrseq_chk #(
    parameter int BG_CYC   = 40,
    parameter int CORE_CYC = 12,
    parameter int ADC_DIV  = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       conv_req,
    input logic       bg_en,
    input logic       ref_en,
    input logic       core_en,
    input logic       adc_clk_en,
    input logic       ready,
    input logic       conv_go,
    input logic       conv_err
);
    int bg_run;
    int core_run;

    // Saturating counts of consecutive cycles each enable has been high
    always_ff @(posedge clk) begin
        if (!rst_n || !bg_en)       bg_run <= 0;
        else if (bg_run < BG_CYC)   bg_run <= bg_run + 1;
        if (!rst_n || !core_en)     core_run <= 0;
        else if (core_run < CORE_CYC) core_run <= core_run + 1;
    end

    a_r1_core_needs_bias: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (bg_en && ref_en));

    a_r2_bg_settled: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_en) && $past(bg_en)) |-> (bg_run >= BG_CYC - 1));

    a_r3_core_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (core_run >= CORE_CYC - 1));

    a_r5_go_gated: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> (ready && conv_req));

    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        conv_err |-> ($past(conv_req) && !$past(ready)));

    a_r7_bias_core_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel) == 2'd1) |-> (!core_en && !ready));

    a_r8_off_modes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel) >= 2'd2) |-> (!bg_en && !ref_en && !core_en && !ready));

    generate
        if (ADC_DIV > 1) begin : g_div_chk
            a_r9_clk_single: assert property (@(posedge clk) disable iff (!rst_n)
                adc_clk_en |=> !adc_clk_en);
        end
    endgenerate
endmodule

bind adc_pwrseq adc_pwrseq_chk #(
    .BG_CYC  (BG_CYC),
    .CORE_CYC(CORE_CYC),
    .ADC_DIV (ADC_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .conv_req  (conv_req),
    .bg_en     (bg_en),
    .ref_en    (ref_en),
    .core_en   (core_en),
    .adc_clk_en(adc_clk_en),
    .ready     (ready),
    .conv_go   (conv_go),
    .conv_err  (conv_err)
);

// File: tb/adc_pwrseq_test.sv
module adc_pwrseq_test;
    localparam int BG   = 40;
    localparam int CORE = 12;
    localparam int DIV  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd3;
    logic       single_step = 1'b0;
    logic       conv_req = 1'b0;
    logic       bg_en, ref_en, core_en, adc_clk_en, ready, conv_go, conv_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_pwrseq #(.BG_CYC(BG), .CORE_CYC(CORE), .ADC_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .single_step(single_step),
        .conv_req(conv_req), .bg_en(bg_en), .ref_en(ref_en), .core_en(core_en),
        .adc_clk_en(adc_clk_en), .ready(ready), .conv_go(conv_go), .conv_err(conv_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return bg_en;
            1: return core_en;
            default: return ready;
        endcase
    endfunction

    // Negedges until the selected output is seen high
    task automatic count_to(input int sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pick(sel) && n < 1000);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R11 outputs in reset", {bg_en, ref_en, core_en, ready, conv_go, conv_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 off after reset", {bg_en, core_en, ready}, 0);
    endtask

    task automatic t_staged();
        int n;
        mode_sel = 2'd0; single_step = 1'b0;
        count_to(0, n);
        check("R1 bias first edge", n, 1);
        check("R1 core off with bias", {ref_en, core_en}, 2'b10);
        count_to(1, n);
        check("R2 bandgap wait", n, BG);
        count_to(2, n);
        check("R3 core wait", n, CORE);
    endtask

    task automatic t_conv_ready();
        conv_req = 1'b1;
        #1 check("R5 go while ready", conv_go, 1);
        @(negedge clk);
        check("R6 no err while ready", conv_err, 0);
        conv_req = 1'b0;
        #1 check("R5 go follows req", conv_go, 0);
    endtask

    task automatic t_bias_reenter();
        int n;
        mode_sel = 2'd1;
        @(negedge clk);
        check("R7 bias drops core/ready", {bg_en, ref_en, core_en, ready}, 4'b1100);
        repeat (5) @(negedge clk);
        check("R7 bias holds", {bg_en, core_en, ready}, 3'b100);
        mode_sel = 2'd0;
        count_to(1, n);
        check("R10 core next edge", n, 1);
        count_to(2, n);
        check("R10 core wait on reentry", n, CORE);
    endtask

    task automatic t_off_clock();
        int pulses;
        int last;
        int gap_bad;
        mode_sel = 2'd2;
        @(negedge clk);
        check("R8 down all off", {bg_en, ref_en, core_en, ready}, 0);
        pulses = 0; last = -1; gap_bad = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (adc_clk_en) begin
                if (last >= 0 && i - last != DIV) gap_bad++;
                last = i;
                pulses++;
            end
        end
        check("R9 pulses in down", pulses, 32 / DIV);
        check("R9 pulse spacing", gap_bad, 0);
        mode_sel = 2'd3;
        pulses = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (adc_clk_en) pulses++;
        end
        check("R9 no pulses in deep", pulses, 0);
        check("R8 deep all off", {bg_en, ref_en, core_en, ready}, 0);
    endtask

    task automatic t_single();
        int n;
        mode_sel = 2'd0; single_step = 1'b1;
        count_to(0, n);
        check("R4 first edge", n, 1);
        check("R4 all enables together", {bg_en, ref_en, core_en}, 3'b111);
        conv_req = 1'b1;
        #1 check("R5 blocked before ready", conv_go, 0);
        @(negedge clk);
        check("R6 err pulse", conv_err, 1);
        conv_req = 1'b0;
        @(negedge clk);
        check("R6 err one cycle", conv_err, 0);
        count_to(2, n);
        check("R4 single wait", n, BG - 2);
        mode_sel = 2'd2;
        @(negedge clk);
        check("R8 down from ready", {bg_en, core_en, ready}, 0);
    endtask

    task automatic t_bias_from_off();
        int n;
        int core_seen;
        mode_sel = 2'd1; single_step = 1'b0;
        count_to(0, n);
        check("R7 bias powers bandgap", n, 1);
        core_seen = 0;
        for (int i = 0; i < BG + 10; i++) begin
            @(negedge clk);
            if (core_en || ready) core_seen++;
        end
        check("R7 core stays off in bias", core_seen, 0);
        mode_sel = 2'd0;
        count_to(1, n);
        check("R10 standby to core", n, 1);
    endtask

    initial begin
        t_reset();
        t_staged();
        t_conv_ready();
        t_bias_reenter();
        t_off_clock();
        t_single();
        t_bias_from_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule